// File: doc/BRIEF.md
# Segmented Tapped Shift Register

This block is a serial shift register of 64 single-bit stages, organised as four consecutive segments of 16 stages. A tap sits after the last stage of every segment and presents that stage's content. In read mode the segments are linked into one continuous chain: the serial input feeds the first stage and every bit walks one stage per rising clock edge toward the final tap. In write mode the three interior taps become inputs. The first stage of segments two to four loads from the tap in front of it instead of from the preceding stage, so all four segments fill side by side and a whole 64-bit word enters in 16 clocks.

The tap pads are bidirectional on a bus. They are modelled here as separate data-in, data-out and output-enable signals. The write-enable input selects the direction of the three interior taps. The final tap always drives. A synchronous active-high reset clears every stage. The register changes state only on the rising clock edge.

Top module: `seg_tap_shreg`

## Requirements
- R1: The register holds SEG_LEN × NUM_SEG stages (default 16 × 4 = 64). In read mode a bit entering the serial input reaches the last tap after exactly 64 rising edges.
- R2: tap_out[k] presents the content of stage 16·(k+1), the last stage of segment k, with index 0 nearest the serial input.
- R3: With wr_en = 0 the stages form one chain. Stage 1 takes ser_in on every rising edge, and each other stage takes the value its predecessor held before the edge.
- R4: With wr_en = 1, stages 17, 33 and 49 load tap_in[0], tap_in[1] and tap_in[2] respectively on the rising edge. Stage 1 still takes ser_in, and every other stage still takes its predecessor's value.
- R5: Over 16 write-mode clocks, let clock j (j = 0..15) drive tap_in[2] = W[j], tap_in[1] = W[16+j], tap_in[0] = W[32+j] and ser_in = W[48+j]. Then 64 following read-mode clocks present W[0], W[1], … W[63] in turn on tap_out[3], each sampled before its shift.
- R6: With wr_en = 0 all four bits of tap_oe are 1.
- R7: With wr_en = 1, tap_oe[0], tap_oe[1] and tap_oe[2] are 0 and tap_oe[3] is 1.
- R8: A rising edge with rst = 1 clears all stages to 0, whatever wr_en, ser_in and tap_in hold.
- R9: In read mode tap_in has no effect on any stage. The outputs follow the chain alone, whatever values tap_in carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data into stage 1 |
| wr_en | input | 1 | 1 = parallel write of segments, 0 = continuous shift |
| tap_in | input | 3 | Data from the interior tap pads, used in write mode |
| tap_out | output | 4 | Content of the last stage of each segment |
| tap_oe | output | 4 | Output enable of each tap pad |

## Verification
The bench builds the block with its default parameters, 16 stages per segment and four segments. This covers the full 64-stage depth, all three interior injection points and the direction switch of each interior tap pad. Random words are loaded in 16-clock bursts and read back through 64 serial shifts, which covers the segment ordering at every boundary. A reset asserted together with write mode, and random data on tap_in during read mode, cover reset priority and the ignored-input case.

// File: rtl/seg_tap_pkg.sv
package seg_tap_pkg;

    typedef enum logic {
        MODE_READ  = 1'b0,
        MODE_WRITE = 1'b1
    } tap_mode_e;

    function automatic tap_mode_e mode_of(input logic wr);
        return wr ? MODE_WRITE : MODE_READ;
    endfunction

endpackage

// File: rtl/seg_tap_segment.sv
module seg_tap_segment #(
    parameter int SEG_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic head_in,
    output logic head_q,
    output logic tail_q
);

    localparam int LAST = SEG_LEN - 1;

    typedef struct packed {
        logic [SEG_LEN-1:0] stg;
    } seg_state_t;

    seg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.stg = '0;
        end else begin
            st_d.stg = {st_q.stg[LAST-1:0], head_in};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign head_q = st_q.stg[0];
    assign tail_q = st_q.stg[LAST];

    AST_SEG_ENTRY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (head_q == $past(head_in))); // R3

    AST_SEG_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tail_q == $past(st_q.stg[LAST-1]))); // R1

    AST_SEG_CLEAR: assert property (@(posedge clk)
        rst |=> (st_q.stg == '0)); // R8

endmodule

// File: rtl/seg_tap_route.sv
module seg_tap_route
    import seg_tap_pkg::*;
#(
    parameter int NUM_SEG = 4
) (
    input  logic               wr_en,
    input  logic               ser_in,
    input  logic [NUM_SEG-2:0] tap_in,
    input  logic [NUM_SEG-1:0] tails,
    output logic [NUM_SEG-1:0] heads,
    output logic [NUM_SEG-1:0] tap_oe
);

    tap_mode_e mode;
    assign mode = mode_of(wr_en);

    assign heads[0]           = ser_in;
    assign tap_oe[NUM_SEG-1]  = 1'b1;

    for (genvar k = 1; k < NUM_SEG; k++) begin : g_link
        assign heads[k]    = (mode == MODE_WRITE) ? tap_in[k-1] : tails[k-1];
        assign tap_oe[k-1] = (mode == MODE_READ);
    end

endmodule

// File: rtl/seg_tap_shreg.sv
module seg_tap_shreg #(
    parameter int SEG_LEN = 16,
    parameter int NUM_SEG = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_in,
    input  logic               wr_en,
    input  logic [NUM_SEG-2:0] tap_in,
    output logic [NUM_SEG-1:0] tap_out,
    output logic [NUM_SEG-1:0] tap_oe
);

    localparam int INNER = NUM_SEG - 1;

    logic [NUM_SEG-1:0] heads;
    logic [NUM_SEG-1:0] head_q;
    logic [NUM_SEG-1:0] tail_q;

    seg_tap_route #(.NUM_SEG(NUM_SEG)) route_i (
        .wr_en  (wr_en),
        .ser_in (ser_in),
        .tap_in (tap_in),
        .tails  (tail_q),
        .heads  (heads),
        .tap_oe (tap_oe)
    );

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
        seg_tap_segment #(.SEG_LEN(SEG_LEN)) seg_i (
            .clk     (clk),
            .rst     (rst),
            .head_in (heads[k]),
            .head_q  (head_q[k]),
            .tail_q  (tail_q[k])
        );
    end

    assign tap_out = tail_q;

    for (genvar k = 1; k < NUM_SEG; k++) begin : g_chk
        AST_TAP_INJECT: assert property (@(posedge clk) disable iff (rst)
            wr_en |=> (head_q[k] == $past(tap_in[k-1]))); // R4
        AST_CHAIN_LINK: assert property (@(posedge clk) disable iff (rst)
            !wr_en |=> (head_q[k] == $past(tail_q[k-1]))); // R3
    end

    AST_OE_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (tap_oe[INNER] && (tap_oe[INNER-1:0] == '0))); // R7

    AST_OE_READ: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (&tap_oe)); // R6

    AST_SERIAL_ENTRY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (head_q[0] == $past(ser_in))); // R3

endmodule

// File: tb/seg_tap_shreg_tb_top.sv
module seg_tap_shreg_tb_top;

    localparam int SL = 16;
    localparam int NS = 4;
    localparam int DEPTH = SL * NS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ser_in = 1'b0;
    logic          wr_en = 1'b0;
    logic [NS-2:0] tap_in = '0;
    logic [NS-1:0] tap_out;
    logic [NS-1:0] tap_oe;

    int vectors = 0;
    int fails = 0;
    logic [DEPTH:1] model = '0;
    logic [DEPTH-1:0] words_q[$];

    always #2 clk = ~clk;

    seg_tap_shreg #(.SEG_LEN(SL), .NUM_SEG(NS)) dut_i (
        .clk(clk), .rst(rst), .ser_in(ser_in), .wr_en(wr_en),
        .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] exp_taps();
        logic [NS-1:0] t;
        for (int k = 0; k < NS; k++) t[k] = model[SL*(k+1)];
        return t;
    endfunction

    // one clock: drive at the current point (after a negedge), check, advance model
    task automatic step(input logic r, input logic we, input logic s, input logic [NS-2:0] ti);
        logic [DEPTH:1] nx;
        rst = r; wr_en = we; ser_in = s; tap_in = ti;
        #0.5;
        if (!r) begin
            if (we) check("R7 tap_oe write", 64'(tap_oe), 64'({1'b1, {(NS-1){1'b0}}}));
            else    check("R6 tap_oe read", 64'(tap_oe), 64'({NS{1'b1}}));
        end
        @(posedge clk);
        if (r) nx = '0;
        else begin
            nx[1] = s;
            for (int i = 2; i <= DEPTH; i++) nx[i] = model[i-1];
            if (we) for (int k = 1; k < NS; k++) nx[SL*k+1] = ti[k-1];
        end
        model = nx;
        @(negedge clk);
        if (r) check("R8 reset clears taps", 64'(tap_out), 64'(0));
        else if (we) check("R4 taps after write clock", 64'(tap_out), 64'(exp_taps()));
        else check("R3 R9 taps after shift", 64'(tap_out), 64'(exp_taps()));
    endtask

    task automatic load_word(input logic [DEPTH-1:0] w);
        for (int j = 0; j < SL; j++)
            step(1'b0, 1'b1, w[3*SL+j], {w[j], w[SL+j], w[2*SL+j]});
        words_q.push_back(w);
    endtask

    task automatic read_word();
        logic [DEPTH-1:0] got, exp;
        for (int i = 0; i < DEPTH; i++) begin
            got[i] = tap_out[NS-1];
            step(1'b0, 1'b0, 1'b0, NS'($urandom) >> 1);
        end
        exp = words_q.pop_front();
        check("R5 word readback", got, exp);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [DEPTH-1:0] w;
        @(negedge clk);
        // R8: reset wins over write mode and live data
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, '1);
        model = '0;
        check("R8 reset state", 64'(tap_out), 64'(0));
        // R1: a single one travels 64 edges to the last tap
        step(1'b0, 1'b0, 1'b1, '0);
        for (int i = 1; i < DEPTH; i++) begin
            check("R1 last tap before arrival", 64'(tap_out[NS-1]), 64'(0));
            step(1'b0, 1'b0, 1'b0, '1);
        end
        check("R1 R2 bit at last tap after 64 edges", 64'(tap_out[NS-1]), 64'(1));
        // R9: random tap_in while shifting random serial data
        for (int i = 0; i < 80; i++) step(1'b0, 1'b0, 1'($urandom), (NS-1)'($urandom));
        // R5: patterned and random words
        load_word({DEPTH{1'b1}});
        read_word();
        load_word(64'hAAAA_5555_F0F0_0FF0);
        read_word();
        for (int n = 0; n < 6; n++) begin
            w = {$urandom, $urandom};
            load_word(w);
            read_word();
        end
        // mixed modes, then reset in the middle
        for (int i = 0; i < 40; i++) step(1'b0, 1'($urandom), 1'($urandom), (NS-1)'($urandom));
        step(1'b1, 1'b0, 1'b1, '1);
        check("R8 mid-run reset", 64'(tap_out), 64'(0));
        w = {$urandom, $urandom};
        load_word(w);
        read_word();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule